// File: doc/BRIEF.md
# Strobed Register-Bus Target

This block is the device-side end of a narrow parallel bus that an external host drives bit by bit. The host drives a byte-wide data bus and four control lines: a chip select, a direction line, a strobe and an address-latch line. Every transfer is one strobe pulse, and before each pulse the host pulls all lines low. The target watches those lines through synchronizers and classifies each strobe rising edge. With the address-latch line high, the edge is an address phase. With it low, the edge is a value phase. The target turns the phases into accesses on an internal register port with a 16-bit word and a byte-wide address.

On a write (direction high), the target takes two value bytes, most significant first, and issues a single write strobe toward the registers. On a read (direction low), it takes a snapshot of the addressed word and drives the upper byte and then the lower byte back onto the data bus. After the value bytes the host raises chip select and polls the busy output. A high level means the access has not finished yet. The host may drop and re-raise chip select to ask again.

Top module: `srb_target`

## Requirements
- R1: A strobe rising edge seen while the address-latch line is high loads the data byte into `reg_addr`, and it stays there until the next address phase.
- R2: On a write (direction = 1), the first value phase after an address phase supplies bits 15:8 and the second supplies bits 7:0. `reg_wdata` carries the assembled word with `reg_addr` during the write pulse.
- R3: `reg_wr` is high for exactly one clock per completed write. It rises one cycle after the second value byte is captured.
- R4: On a read (direction = 0), the word at `reg_addr` is sampled at the first value phase. Bits 15:8 are driven on `bus_dout` in that phase and bits 7:0 of the same snapshot in the second, even if the register changes in between.
- R5: `bus_doe` is high only while direction is 0, chip select is 0, the strobe is still high and a first or second read value phase is in progress. Address phases and write phases never enable it.
- R6: A new phase is recognised only after the strobe has been seen low. A strobe held high, including one that is already high when reset is released, causes no new capture when data or address-latch change.
- R7: A value phase when no phase slot is open is ignored: it writes nothing and drives nothing. This covers a third value phase after an address phase, and any value phase after reset before the first address phase.
- R8: The first chip-select rising edge after a completed access raises `bus_busy` for exactly `BUSY_CYC` cycles. `bus_busy` is only ever high while chip select is high.
- R9: A chip-select rising edge reports not busy once the access has already been reported complete, or when no access has completed since the last address phase.
- R10: If chip select falls while `bus_busy` is high, the report is abandoned. The next chip-select rising edge starts a full `BUSY_CYC` count again.
- R11: While reset is held and right after it, `bus_busy`, `bus_doe`, `reg_wr` and `reg_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Chip select from host; high ends an access and requests status |
| bus_dir | input | 1 | Transfer direction: 1 host writes, 0 host reads |
| bus_stb | input | 1 | Phase strobe; rising edge marks a phase |
| bus_alat | input | 1 | Address latch: 1 address phase, 0 value phase |
| bus_din | input | DW | Data bus as seen at the pins |
| bus_dout | output | DW | Byte driven toward the host on reads |
| bus_doe | output | 1 | Output enable for `bus_dout`; low means tri-stated |
| bus_busy | output | 1 | Busy status to host; high means not yet complete |
| reg_addr | output | DW | Register address for the internal port |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 2*DW | Register write word |
| reg_rdata | input | 2*DW | Register read word for `reg_addr` |

## Verification
The hardest case to reach is the abandoned busy report. It needs a chip-select pulse short enough that it ends inside the busy window, after the synchronizer delay, and then a second rising edge that must restart the full count. The bench builds the design with a longer busy count so that the partial and full windows can be told apart. It holds chip select high for only two cycles before the real poll. To check the read snapshot, the bench rewrites the addressed register between the two read strobes through a side port of its register model.

// File: rtl/srb_pkg.sv
package srb_pkg;

  // Which value slot the next value phase fills.
  typedef enum logic [1:0] {
    VS_HI   = 2'd0,
    VS_LO   = 2'd1,
    VS_OVER = 2'd2
  } vslot_e;

  // Synchronized view of the control lines.
  typedef struct packed {
    logic sel;
    logic dir;
    logic stb;
    logic alat;
  } bus_ctrl_t;

  localparam int CTRL_W = $bits(bus_ctrl_t);

endpackage

// File: rtl/srb_sync.sv
module srb_sync #(
  parameter int             W      = 1,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= INIT;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/srb_phase.sv
module srb_phase
  import srb_pkg::*;
#(
  parameter int DW = 8,
  localparam int RW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_rise,
  input  logic          stb_level,
  input  logic          alat,
  input  logic          dir,
  input  logic          cs,
  input  logic [DW-1:0] din,
  input  logic [RW-1:0] reg_rdata,
  output logic [DW-1:0] reg_addr,
  output logic          reg_wr,
  output logic [RW-1:0] reg_wdata,
  output logic [DW-1:0] dout,
  output logic          doe,
  output logic          acc_done,
  output logic          addr_seen
);

  vslot_e        slot_q;
  logic [DW-1:0] addr_q, hi_q, lo_q, dout_q;
  logic [RW-1:0] snap_q;
  logic          wr_pend_q, wr_q, rd_phase_q, doe_q, done_q, aseen_q;

  logic addr_ev, val_live, rd_start, rd_hold;

  always_comb begin
    addr_ev  = stb_rise & alat;
    val_live = stb_rise & ~alat & (slot_q != VS_OVER);
    rd_start = val_live & ~dir;
    rd_hold  = stb_level & (rd_start | rd_phase_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q     <= VS_OVER;
      addr_q     <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      dout_q     <= '0;
      snap_q     <= '0;
      wr_pend_q  <= 1'b0;
      wr_q       <= 1'b0;
      rd_phase_q <= 1'b0;
      doe_q      <= 1'b0;
      done_q     <= 1'b0;
      aseen_q    <= 1'b0;
    end else begin
      aseen_q    <= addr_ev;
      done_q     <= 1'b0;
      wr_q       <= wr_pend_q;
      wr_pend_q  <= 1'b0;
      rd_phase_q <= rd_hold;
      doe_q      <= rd_hold & ~dir & ~cs;
      if (addr_ev) begin
        addr_q <= din;
        slot_q <= VS_HI;
      end else if (val_live) begin
        case (slot_q)
          VS_HI: begin
            if (dir) begin
              hi_q <= din;
            end else begin
              snap_q <= reg_rdata;
              dout_q <= reg_rdata[RW-1:DW];
            end
            slot_q <= VS_LO;
          end
          default: begin
            if (dir) begin
              lo_q      <= din;
              wr_pend_q <= 1'b1;
            end else begin
              dout_q <= snap_q[DW-1:0];
            end
            done_q <= 1'b1;
            slot_q <= VS_OVER;
          end
        endcase
      end
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wr    = wr_q;
  assign reg_wdata = {hi_q, lo_q};
  assign dout      = dout_q;
  assign doe       = doe_q;
  assign acc_done  = done_q;
  assign addr_seen = aseen_q;

  // R3: the write strobe never lasts two cycles
  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  // R7: a value phase with no open slot leaves the write word and strobe alone
  p_over_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (stb_rise && !alat && slot_q == VS_OVER) |=> ($stable(reg_wdata) && !wr_pend_q));

endmodule

// File: rtl/srb_busy.sv
module srb_busy #(
  parameter int BUSY_CYC = 2,
  localparam int CW = $clog2(BUSY_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_rise,
  input  logic cs_fall,
  input  logic acc_done,
  input  logic addr_seen,
  output logic busy
);

  logic          busy_q, pend_q, fin_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      fin_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (addr_seen) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      if (acc_done) begin
        pend_q <= 1'b1;
        fin_q  <= 1'b0;
      end
      if (cs_rise && pend_q && !fin_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(BUSY_CYC - 1);
      end else if (cs_fall) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;

  // R8: the busy window closes when its count runs out
  p_busy_end_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q == '0 && !cs_fall && !addr_seen) |=> !busy_q);

  // R9: once reported complete, a new select edge reports not busy
  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && fin_q && !acc_done && !addr_seen) |=> !busy_q);

endmodule

// File: rtl/srb_target.sv
module srb_target
  import srb_pkg::*;
#(
  parameter int DW          = 8,
  parameter int BUSY_CYC    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int RW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs,
  input  logic          bus_dir,
  input  logic          bus_stb,
  input  logic          bus_alat,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic          bus_busy,
  output logic [DW-1:0] reg_addr,
  output logic          reg_wr,
  output logic [RW-1:0] reg_wdata,
  input  logic [RW-1:0] reg_rdata
);

  bus_ctrl_t     ctl_raw, ctl_s;
  logic [DW-1:0] din_s;
  logic          stb_prev_q, cs_prev_q;
  logic          stb_rise, cs_rise, cs_fall;
  logic          acc_done, addr_seen;

  assign ctl_raw = '{sel: bus_cs, dir: bus_dir, stb: bus_stb, alat: bus_alat};

  // Control lines reset to their idle-high level so nothing looks like an edge.
  srb_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .INIT({CTRL_W{1'b1}})) u_ctl_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctl_raw),
    .q   (ctl_s)
  );

  srb_sync #(.W(DW), .STAGES(SYNC_STAGES), .INIT('0)) u_dat_sync (
    .clk (clk),
    .rst (rst),
    .d   (bus_din),
    .q   (din_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_prev_q <= 1'b1;
      cs_prev_q  <= 1'b1;
    end else begin
      stb_prev_q <= ctl_s.stb;
      cs_prev_q  <= ctl_s.sel;
    end
  end

  assign stb_rise = ctl_s.stb & ~stb_prev_q;
  assign cs_rise  = ctl_s.sel & ~cs_prev_q;
  assign cs_fall  = ~ctl_s.sel & cs_prev_q;

  srb_phase #(.DW(DW)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .stb_rise  (stb_rise),
    .stb_level (ctl_s.stb),
    .alat      (ctl_s.alat),
    .dir       (ctl_s.dir),
    .cs        (ctl_s.sel),
    .din       (din_s),
    .reg_rdata (reg_rdata),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .dout      (bus_dout),
    .doe       (bus_doe),
    .acc_done  (acc_done),
    .addr_seen (addr_seen)
  );

  srb_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk       (clk),
    .rst       (rst),
    .cs_rise   (cs_rise),
    .cs_fall   (cs_fall),
    .acc_done  (acc_done),
    .addr_seen (addr_seen),
    .busy      (bus_busy)
  );

  // R5: a steady write direction never enables the data drivers
  p_oe_dir_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_s.dir && $past(ctl_s.dir)) |-> !bus_doe);

  // R8: busy is only shown while chip select was high
  p_busy_cs_r8: assert property (@(posedge clk) disable iff (rst)
    bus_busy |-> $past(ctl_s.sel));

  // R11: reset clears the host-visible status
  p_reset_r11: assert property (@(posedge clk)
    $past(rst) |-> (!bus_busy && !bus_doe && !reg_wr));

endmodule

// File: tb/srb_target_bench.sv
module srb_target_bench;

  localparam int DW   = 8;
  localparam int RW   = 16;
  localparam int BUSY = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_cs, bus_dir, bus_stb, bus_alat;
  logic [DW-1:0] bus_din, bus_dout, reg_addr;
  logic          bus_doe, bus_busy, reg_wr;
  logic [RW-1:0] reg_wdata, reg_rdata;

  always #4 clk = ~clk;

  srb_target #(.DW(DW), .BUSY_CYC(BUSY)) u_srb_target (
    .clk       (clk),
    .rst       (rst),
    .bus_cs    (bus_cs),
    .bus_dir   (bus_dir),
    .bus_stb   (bus_stb),
    .bus_alat  (bus_alat),
    .bus_din   (bus_din),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .bus_busy  (bus_busy),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  // Register array model with a side port for mid-access changes.
  logic [RW-1:0] mem [256];
  logic          poke_en = 1'b0;
  logic [7:0]    poke_addr = '0;
  logic [RW-1:0] poke_val = '0;

  function automatic logic [RW-1:0] init_val(input int i);
    return RW'(i * 257) ^ 16'h5a3c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else begin
      if (reg_wr) mem[reg_addr] <= reg_wdata;
      if (poke_en) mem[poke_addr] <= poke_val;
    end
  end

  assign reg_rdata = mem[reg_addr];

  // Scoreboard
  typedef struct packed { logic [7:0] a; logic [RW-1:0] v; } wr_item_t;
  wr_item_t exp_q[$];
  int checks = 0, errors = 0, mon_checks = 0, mon_errors = 0, wr_seen = 0;
  logic wr_prev = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (reg_wr) begin
        wr_item_t it;
        wr_seen++;
        mon_checks++;
        if (exp_q.size() == 0) begin
          mon_errors++;
          $display("FAIL R7 unexpected write actual=%0h/%0h expected=none", reg_addr, reg_wdata);
        end else begin
          it = exp_q.pop_front();
          if (reg_addr != it.a || reg_wdata != it.v) begin
            mon_errors++;
            $display("FAIL R2 write actual=%0h/%0h expected=%0h/%0h", reg_addr, reg_wdata, it.a, it.v);
          end
        end
        mon_checks++;
        if (wr_prev) begin
          mon_errors++;
          $display("FAIL R3 write strobe width actual=2+ expected=1");
        end
      end
      wr_prev <= reg_wr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_low();
    bus_stb = 1'b0; bus_cs = 1'b0; bus_alat = 1'b0; bus_din = '0;
    step(4);
  endtask

  task automatic phase(input logic al, input logic [7:0] b);
    bus_low();
    bus_alat = al; bus_din = b;
    step(2);
    bus_stb = 1'b1;
    step(6);
  endtask

  task automatic measure_busy(output int n);
    int k = 0;
    n = 0;
    bus_cs = 1'b1;
    step(1);
    while (!bus_busy && k < 8) begin step(1); k++; end
    while (bus_busy && n < 50) begin n++; step(1); end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [RW-1:0] v,
                          input bit third, input bit report);
    int n;
    bus_dir = 1'b1;
    phase(1'b1, a);
    chk(reg_addr == a, "R1 address capture", 32'(reg_addr), 32'(a));
    phase(1'b0, v[15:8]);
    chk(!bus_doe, "R5 no drive on write phase", 32'(bus_doe), 0);
    exp_q.push_back('{a: a, v: v});
    phase(1'b0, v[7:0]);
    if (third) phase(1'b0, 8'h99);  // R7: must be ignored
    if (report) begin
      measure_busy(n);
      chk(n == BUSY, "R8 busy after write", 32'(n), BUSY);
    end
  endtask

  task automatic do_read(input logic [7:0] a, input logic [RW-1:0] exp, input bit poke);
    int n;
    bus_dir = 1'b0;
    phase(1'b1, a);
    chk(!bus_doe, "R5 no drive on address phase", 32'(bus_doe), 0);
    bus_low();
    bus_stb = 1'b1;
    step(6);
    chk(bus_doe, "R5 drive on first read phase", 32'(bus_doe), 1);
    chk(bus_dout == exp[15:8], "R4 upper byte", 32'(bus_dout), 32'(exp[15:8]));
    bus_low();
    chk(!bus_doe, "R5 released after strobe low", 32'(bus_doe), 0);
    if (poke) begin
      poke_addr = a; poke_val = ~exp; poke_en = 1'b1;
      step(1);
      poke_en = 1'b0;
    end
    bus_stb = 1'b1;
    step(6);
    chk(bus_doe, "R5 drive on second read phase", 32'(bus_doe), 1);
    chk(bus_dout == exp[7:0], "R4 lower byte from snapshot", 32'(bus_dout), 32'(exp[7:0]));
    bus_low();
    bus_stb = 1'b1;
    step(6);
    chk(!bus_doe, "R7 third read phase not driven", 32'(bus_doe), 0);
    measure_busy(n);
    chk(n == BUSY, "R8 busy after read", 32'(n), BUSY);
    bus_dir = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1;
    bus_cs = 1'b1; bus_dir = 1'b1; bus_stb = 1'b1; bus_alat = 1'b1; bus_din = 8'hff;
    step(5);
    rst = 1'b0;
    step(1);
    // R11
    chk(!bus_busy, "R11 busy after reset", 32'(bus_busy), 0);
    chk(!bus_doe, "R11 doe after reset", 32'(bus_doe), 0);
    chk(reg_addr == 0, "R11 addr after reset", 32'(reg_addr), 0);
    chk(!reg_wr, "R11 write strobe after reset", 32'(reg_wr), 0);
    // R6: strobe high out of reset is not a phase
    step(6);
    chk(reg_addr == 0, "R6 held strobe from reset", 32'(reg_addr), 0);

    // R7: value phases before any address phase are ignored
    bus_dir = 1'b1;
    phase(1'b0, 8'h12);
    phase(1'b0, 8'h34);
    step(3);
    chk(wr_seen == 0, "R7 value before address", 32'(wr_seen), 0);

    // R2 R3 R8 plain write, then R9 re-poll
    do_write(8'h11, 16'hbeef, 1'b0, 1'b1);
    bus_cs = 1'b0; step(3);
    measure_busy(n);
    chk(n == 0, "R9 re-poll after completion", 32'(n), 0);

    // R7: third value byte of a write ignored
    do_write(8'h42, 16'h1234, 1'b1, 1'b1);
    chk(wr_seen == 2, "R7 writes counted", 32'(wr_seen), 2);

    // R6: data change under a held strobe
    bus_dir = 1'b1;
    phase(1'b1, 8'h30);
    bus_din = 8'h31; bus_alat = 1'b0;
    step(6);
    chk(reg_addr == 8'h30, "R6 held strobe ignores change", 32'(reg_addr), 32'h30);
    chk(wr_seen == 2, "R6 no write from held strobe", 32'(wr_seen), 2);

    // R9: poll with no completed access since address phase
    measure_busy(n);
    chk(n == 0, "R9 poll with no access", 32'(n), 0);

    // R4 reads: written word (third byte ignored), then snapshot check
    do_read(8'h42, 16'h1234, 1'b0);
    do_read(8'h77, init_val(8'h77), 1'b1);
    do_read(8'h11, 16'hbeef, 1'b0);

    // R10: short chip-select pulse abandons the report
    do_write(8'h05, 16'ha5c3, 1'b0, 1'b0);
    bus_cs = 1'b1; step(2);
    bus_cs = 1'b0; step(4);
    measure_busy(n);
    chk(n == BUSY, "R10 full count after abandon", 32'(n), BUSY);
    bus_cs = 1'b0; step(3);
    measure_busy(n);
    chk(n == 0, "R9 after restarted report", 32'(n), 0);
    do_read(8'h05, 16'ha5c3, 1'b0);

    step(4);
    chk(exp_q.size() == 0, "R2 all writes seen", 32'(exp_q.size()), 0);
    chk(wr_seen == 3, "R3 one strobe per write", 32'(wr_seen), 3);
    $display("  CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
    $finish;
  end

endmodule